// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins an A bus and a B bus through a number of independent byte-wide sections (two by default). Every section holds one register that samples the A side and one that samples the B side. Each direction has a capture strobe, a source choice and an output enable of its own. The B side is driven from either the live A input or the stored A copy, and the A side is driven from either the live B input or the stored B copy. Because the block is written for synthesis, each bus appears as three signals: an input, an output and an output-enable. No tri-state pins are used.

Capture strobes are level signals sampled in the single system clock domain. A register loads when its strobe is seen high after being low, and this happens whatever the selects and enables are doing. A register always samples the value actually present on its bus. If the block is driving that bus, this is the driven value. So a stored value sent onto one bus can be captured into the opposite register, and both registers then hold the same data. Typical uses are isolation, pass-through in either direction, latching a snapshot of one or both buses, and replaying stored data onto both buses at the same time.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: A synchronous active-low reset clears both registers of every section to zero. With both selects high and both directions enabled after reset, both outputs read zero.
- R2: In each section, `b_oe` follows `ab_oe` (active high) and `a_oe` is the inverse of `ba_oe_n` (active low). With `ab_oe`=0 and `ba_oe_n`=1 neither bus is driven.
- R3: When `ab_sel` of a section is 0, its `b_out` slice equals the current `a_in` slice in the same cycle (live A to B).
- R4: When `ab_sel` of a section is 1, its `b_out` slice equals the stored A register of that section.
- R5: When `ba_sel` of a section is 0, its `a_out` slice equals the current `b_in` slice (live B to A).
- R6: When `ba_sel` of a section is 1, its `a_out` slice equals the stored B register of that section.
- R7: The A register loads only at the first clock edge where `ab_clk` is sampled high after having been sampled low, and likewise the B register with `ba_clk`. Capture does not depend on the selects or enables. A strobe held high does not reload the register.
- R8: The value captured is the effective bus: `a_out` when `a_oe` is high, otherwise `a_in` (B side alike). This lets one stored value be copied into both registers.
- R9: Sections are independent. The controls of one section never change the registers or outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | NS*W | Value seen on the A bus pins |
| a_out | output | NS*W | Value the block drives onto the A bus |
| a_oe | output | NS | Per-section A bus drive enable |
| b_in | input | NS*W | Value seen on the B bus pins |
| b_out | output | NS*W | Value the block drives onto the B bus |
| b_oe | output | NS | Per-section B bus drive enable |
| ab_clk | input | NS | Per-section A register capture strobe |
| ba_clk | input | NS | Per-section B register capture strobe |
| ab_sel | input | NS | B output source: 0 live A, 1 stored A |
| ba_sel | input | NS | A output source: 0 live B, 1 stored B |
| ab_oe | input | NS | Enable for driving B, active high |
| ba_oe_n | input | NS | Enable for driving A, active low |

## Verification
The assertions check in every cycle the output source chosen by each select, the load-on-rising-strobe rule together with the effective-bus capture value, register stability when no edge is seen, and the cleared state after reset. The bench covers what needs a sequence of cycles: isolation, loading one value into both registers by looping a stored value back, a strobe held high across many cycles, and one section kept untouched while the other is exercised. Random traffic is compared against a function-table model in the bench.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  function automatic logic f_rise(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  function automatic logic f_drive_a(input logic oe_n);
    return ~oe_n;
  endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe,
  output logic [N-1:0] fire
);
  import xcvr_pkg::*;

  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= strobe;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign fire[i] = f_rise(strobe[i], prev_q[i]);
  end

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_fire,
  input  logic         ba_fire,
  input  logic         ab_sel,
  input  logic         ba_sel,
  input  logic         ab_oe,
  input  logic         ba_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q
);
  import xcvr_pkg::*;

  function automatic logic [W-1:0] f_pick(input src_e src, input logic [W-1:0] stored,
                                          input logic [W-1:0] live);
    return (src == SRC_STORED) ? stored : live;
  endfunction

  logic [W-1:0] a_bus;
  logic [W-1:0] b_bus;

  // Outputs are a single mux between a register and a raw input pin.
  assign b_out = f_pick(src_e'(ab_sel), a_q, a_in);
  assign a_out = f_pick(src_e'(ba_sel), b_q, b_in);
  assign b_oe  = ab_oe;
  assign a_oe  = f_drive_a(ba_oe_n);

  // Effective bus value: what the block drives, else what the pins show.
  assign a_bus = a_oe ? a_out : a_in;
  assign b_bus = b_oe ? b_out : b_in;

  xcvr_store #(.W(W)) u_a_reg (
    .clk(clk), .rst_n(rst_n), .load(ab_fire), .d(a_bus), .q(a_q)
  );

  xcvr_store #(.W(W)) u_b_reg (
    .clk(clk), .rst_n(rst_n), .load(ba_fire), .d(b_bus), .q(b_q)
  );

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int NS = 2,
  parameter int W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS*W-1:0] a_in,
  output logic [NS*W-1:0] a_out,
  output logic [NS-1:0]   a_oe,
  input  logic [NS*W-1:0] b_in,
  output logic [NS*W-1:0] b_out,
  output logic [NS-1:0]   b_oe,
  input  logic [NS-1:0]   ab_clk,
  input  logic [NS-1:0]   ba_clk,
  input  logic [NS-1:0]   ab_sel,
  input  logic [NS-1:0]   ba_sel,
  input  logic [NS-1:0]   ab_oe,
  input  logic [NS-1:0]   ba_oe_n
);

  localparam int TW = NS * W;

  // Named internal events for the checker.
  logic [NS-1:0] ab_fire;
  logic [NS-1:0] ba_fire;
  logic [TW-1:0] a_store;
  logic [TW-1:0] b_store;

  xcvr_edge #(.N(NS)) u_ab_edge (
    .clk(clk), .rst_n(rst_n), .strobe(ab_clk), .fire(ab_fire)
  );

  xcvr_edge #(.N(NS)) u_ba_edge (
    .clk(clk), .rst_n(rst_n), .strobe(ba_clk), .fire(ba_fire)
  );

  for (genvar s = 0; s < NS; s++) begin : g_sec
    xcvr_section #(.W(W)) u_sec (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_in    (a_in[s*W +: W]),
      .b_in    (b_in[s*W +: W]),
      .ab_fire (ab_fire[s]),
      .ba_fire (ba_fire[s]),
      .ab_sel  (ab_sel[s]),
      .ba_sel  (ba_sel[s]),
      .ab_oe   (ab_oe[s]),
      .ba_oe_n (ba_oe_n[s]),
      .a_out   (a_out[s*W +: W]),
      .a_oe    (a_oe[s]),
      .b_out   (b_out[s*W +: W]),
      .b_oe    (b_oe[s]),
      .a_q     (a_store[s*W +: W]),
      .b_q     (b_store[s*W +: W])
    );
  end

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int NS = 2,
  parameter int W  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NS*W-1:0] a_in,
  input logic [NS*W-1:0] a_out,
  input logic [NS-1:0]   a_oe,
  input logic [NS*W-1:0] b_in,
  input logic [NS*W-1:0] b_out,
  input logic [NS-1:0]   b_oe,
  input logic [NS-1:0]   ab_sel,
  input logic [NS-1:0]   ba_sel,
  input logic [NS-1:0]   ab_oe,
  input logic [NS-1:0]   ba_oe_n,
  input logic [NS-1:0]   ab_fire,
  input logic [NS-1:0]   ba_fire,
  input logic [NS*W-1:0] a_store,
  input logic [NS*W-1:0] b_store
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (a_store == '0 && b_store == '0)); // R1

  for (genvar i = 0; i < NS; i++) begin : g_chk
    AST_OE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe[i] == ab_oe[i]) && (a_oe[i] != ba_oe_n[i])); // R2
    AST_B_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !ab_sel[i] |-> b_out[i*W +: W] == a_in[i*W +: W]); // R3
    AST_B_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      ab_sel[i] |-> b_out[i*W +: W] == a_store[i*W +: W]); // R4
    AST_A_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !ba_sel[i] |-> a_out[i*W +: W] == b_in[i*W +: W]); // R5
    AST_A_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      ba_sel[i] |-> a_out[i*W +: W] == b_store[i*W +: W]); // R6
    AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ab_fire[i] |=> $stable(a_store[i*W +: W])); // R7
    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ba_fire[i] |=> $stable(b_store[i*W +: W])); // R7
    AST_A_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      ab_fire[i] |=> a_store[i*W +: W] ==
        $past(a_oe[i] ? a_out[i*W +: W] : a_in[i*W +: W])); // R8
    AST_B_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      ba_fire[i] |=> b_store[i*W +: W] ==
        $past(b_oe[i] ? b_out[i*W +: W] : b_in[i*W +: W])); // R8
  end

endmodule

bind bidir_reg_xcvr xcvr_checker #(.NS(NS), .W(W)) u_xcvr_checker (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_sel(ab_sel), .ba_sel(ba_sel),
  .ab_oe(ab_oe), .ba_oe_n(ba_oe_n), .ab_fire(ab_fire), .ba_fire(ba_fire),
  .a_store(a_store), .b_store(b_store)
);

// File: tb/bidir_reg_xcvr_bench.sv
module bidir_reg_xcvr_bench;

  localparam int NS = 2;
  localparam int W  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS*W-1:0] a_in = '0, b_in = '0;
  logic [NS-1:0]   ab_clk = '0, ba_clk = '0, ab_sel = '0, ba_sel = '0;
  logic [NS-1:0]   ab_oe = '0, ba_oe_n = '1;
  logic [NS*W-1:0] a_out, b_out;
  logic [NS-1:0]   a_oe, b_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // Reference model state
  logic [W-1:0] ma [NS];
  logic [W-1:0] mb [NS];
  logic [NS-1:0] pab, pba;

  always #5 clk = ~clk;

  bidir_reg_xcvr #(.NS(NS), .W(W)) u_bidir_reg_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_clk(ab_clk), .ba_clk(ba_clk),
    .ab_sel(ab_sel), .ba_sel(ba_sel), .ab_oe(ab_oe), .ba_oe_n(ba_oe_n)
  );

  function automatic logic [W-1:0] exp_b(input int s);
    if (ab_sel[s]) return ma[s];
    return a_in[s*W +: W];
  endfunction

  function automatic logic [W-1:0] exp_a(input int s);
    if (ba_sel[s]) return mb[s];
    return b_in[s*W +: W];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Compare all outputs against the model, then advance one clock.
  task automatic step();
    logic [W-1:0] na [NS];
    logic [W-1:0] nb [NS];
    #1;
    for (int s = 0; s < NS; s++) begin
      chk("R2 b_oe", 32'(b_oe[s]), 32'(ab_oe[s]));
      chk("R2 a_oe", 32'(a_oe[s]), 32'(!ba_oe_n[s]));
      chk(ab_sel[s] ? "R4 b_out stored" : "R3 b_out live", 32'(b_out[s*W +: W]), 32'(exp_b(s)));
      chk(ba_sel[s] ? "R6 a_out stored" : "R5 a_out live", 32'(a_out[s*W +: W]), 32'(exp_a(s)));
      na[s] = ma[s];
      nb[s] = mb[s];
      if (ab_clk[s] && !pab[s]) na[s] = !ba_oe_n[s] ? exp_a(s) : a_in[s*W +: W];
      if (ba_clk[s] && !pba[s]) nb[s] = ab_oe[s] ? exp_b(s) : b_in[s*W +: W];
    end
    @(posedge clk);
    for (int s = 0; s < NS; s++) begin
      ma[s] = na[s];
      mb[s] = nb[s];
    end
    pab = ab_clk;
    pba = ba_clk;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++) begin ma[s] = '0; mb[s] = '0; end
    pab = '0; pba = '0;
    ab_clk = '1; ba_clk = '1;
    a_in = '1; b_in = '1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    ab_clk = '0; ba_clk = '0;
    rst_n = 1'b1;

    // R1: cleared registers read back through stored paths
    ab_sel = '1; ba_sel = '1; ab_oe = '1; ba_oe_n = '0;
    #1;
    chk("R1 b_out after reset", 32'(b_out), 32'h0);
    chk("R1 a_out after reset", 32'(a_out), 32'h0);
    step();

    // R2: isolation
    ab_oe = '0; ba_oe_n = '1; ab_sel = '0; ba_sel = '0;
    #1;
    chk("R2 isolation a_oe", 32'(a_oe), 32'h0);
    chk("R2 isolation b_oe", 32'(b_oe), 32'h0);
    step();

    // R7: load A of section 0 with 5A (A not driven)
    a_in = 16'h775A; ab_clk = 2'b01;
    step();
    // held high: new bus value must not reload
    a_in = 16'h0011;
    repeat (3) step();
    ab_sel = '1; ab_oe = '1;
    #1;
    chk("R7 held strobe no reload", 32'(b_out[7:0]), 32'h5A);
    chk("R9 section 1 A untouched", 32'(b_out[15:8]), 32'h00);
    step();

    // R8: B driven from stored A, B strobe copies it into B register
    b_in = 16'hC3C3; ba_clk = 2'b01; ab_clk = '0;
    step();
    ba_clk = '0; ab_oe = '0; ba_sel = '1; ba_oe_n = '0;
    #1;
    chk("R8 stored A copied into B", 32'(a_out[7:0]), 32'h5A);
    chk("R9 section 1 B untouched", 32'(a_out[15:8]), 32'h00);
    step();

    // R8: A driven from stored B, A strobe reloads A from driven bus
    b_in = '0; a_in = 16'hFFFF; ab_clk = 2'b10;
    step();
    ab_clk = '0; ab_sel = '1;
    #1;
    chk("R8 A captured driven value", 32'(b_out[15:8]), 32'h00);
    step();

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      a_in = 16'($urandom); b_in = 16'($urandom);
      ab_clk = 2'($urandom); ba_clk = 2'($urandom);
      ab_sel = 2'($urandom); ba_sel = 2'($urandom);
      ab_oe = 2'($urandom); ba_oe_n = 2'($urandom);
      step();
    end

    summary();
  end

endmodule